// File: doc/BRIEF.md
# Loop Replay Micro-op Issue Buffer

This block sits between a decoder and a four-wide allocation stage. Normally it passes the decoder's issue group straight through. When told to start, it records the micro-ops of a short loop body as they come from the decoder. The loop body is closed by a micro-op flagged as the taken backward branch. The block then stops using the decode path and replays the stored body on its own, up to four micro-ops per cycle, for as long as it is not flushed.

A replayed group never spans the loop's closing branch. The branch is always the last valid lane of its group, and the first micro-op of the next iteration opens the next cycle's group. A body whose length is not a multiple of four therefore loses slots on every iteration. One iteration takes the body length divided by four, rounded up, in cycles. A seven-entry body, for example, issues in groups of 4 and 3. Two counters give the micro-ops accepted downstream and the cycles in which a group was accepted, so the slot loss can be measured.

Top module: `loop_replay_buf`

## Requirements
- R1: When the block is not replaying (after reset, during capture, after overflow or flush), out_valid, out_uop and out_br equal dec_valid, dec_uop and dec_br in the same cycle. After reset both counters read zero.
- R2: A start pulse empties the buffer, clears both counters and begins capture. Each following cycle with cap_valid high stores one entry in arrival order. The entry with cap_br high closes the body, and replay begins in the next cycle with the group starting at the first stored entry.
- R3: During replay, lane i (out_uop bits i*UOP_W up to i*UOP_W+UOP_W-1, lane 0 oldest) carries stored entry p+i. Here p is the group's start index. The valid lanes are always contiguous from lane 0, with out_valid one of 0001, 0011, 0111 or 1111.
- R4: The closing branch (out_br high) is always the highest valid lane of its group, and the lanes above it are invalid. The group after it starts again at stored entry 0.
- R5: Every accepted replay group (out_ready high) adds its number of valid lanes to cnt_uops and one to cnt_cycles. A body of L entries therefore costs ceil(L/4) cycles per iteration and L micro-ops per iteration.
- R6: While out_ready is low during replay, the offered group stays unchanged and the counters do not move.
- R7: If a capture reaches entry DEPTH+1 with no closing branch, capture is aborted and the block stays in pass-through. Later captured micro-ops are then ignored until the next start.
- R8: A flush pulse empties the buffer and ends replay or capture. From the next cycle the output is pass-through, and captured micro-ops are ignored until the next start.
- R9: A seven-entry body issues the repeating valid pattern 1111, 0111, 1111, 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin capturing a new loop body |
| flush | input | 1 | Empty buffer and return to pass-through |
| cap_valid | input | 1 | Capture micro-op present |
| cap_uop | input | UOP_W | Captured micro-op |
| cap_br | input | 1 | Captured micro-op is the loop-closing taken branch |
| dec_valid | input | 4 | Decode path lane valids |
| dec_uop | input | 4*UOP_W | Decode path micro-ops |
| dec_br | input | 4 | Decode path branch flags |
| out_ready | input | 1 | Allocation stage accepts the offered group |
| out_valid | output | 4 | Issue group lane valids |
| out_uop | output | 4*UOP_W | Issue group micro-ops |
| out_br | output | 4 | Issue group closing-branch flags |
| cnt_uops | output | CNT_W | Micro-ops accepted during replay |
| cnt_cycles | output | CNT_W | Replay groups accepted |

## Verification
Every body length from 1 up to the full capacity is captured and replayed for three iterations under a stalling ready pattern. Lengths of 4N+1, 4N+2 and 4N+3 tell correct cutting at the branch apart from packing across iterations, and the seven-entry case shows the 4/3 alternation. Lengths that are exact multiples of four show that no empty group is inserted. The stalled cycles separate holding from advancing. A body of exactly capacity entries against one entry too many tells the overflow limit apart from an off-by-one. A flush in mid-replay followed by a capture with no start shows that the buffer has truly been emptied.

// File: rtl/loop_replay_buf.sv
module loop_replay_buf #(
  parameter int UOP_W = 16,
  parameter int DEPTH = 28,
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 flush,
  input  logic                 cap_valid,
  input  logic [UOP_W-1:0]     cap_uop,
  input  logic                 cap_br,
  input  logic [3:0]           dec_valid,
  input  logic [4*UOP_W-1:0]   dec_uop,
  input  logic [3:0]           dec_br,
  input  logic                 out_ready,
  output logic [3:0]           out_valid,
  output logic [4*UOP_W-1:0]   out_uop,
  output logic [3:0]           out_br,
  output logic [CNT_W-1:0]     cnt_uops,
  output logic [CNT_W-1:0]     cnt_cycles
);
  localparam int LANES = 4;
  localparam int LW = $clog2(DEPTH + LANES) + 1;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_CAPT, S_PLAY} mode_t;
  mode_t mode;

  logic [UOP_W-1:0] mem_u [DEPTH];
  logic [DEPTH-1:0] mem_b;
  logic [LW-1:0]    wp, len, rp;

  wire playing   = (mode == S_PLAY);
  wire capturing = (mode == S_CAPT);
  wire cap_fire  = capturing && cap_valid;
  wire cap_over  = cap_fire && (wp == LW'(DEPTH));
  wire cap_store = cap_fire && !cap_over;
  wire adv       = playing && out_ready;

  logic [LANES-1:0]       pv, pb;
  logic [LANES*UOP_W-1:0] pu;
  logic [LW-1:0]          nrp;

  always_comb begin
    logic [LW-1:0] idx;
    pv = '0;
    pb = '0;
    pu = '0;
    for (int i = 0; i < LANES; i++) begin
      idx = rp + LW'(i);
      pv[i] = (idx < len);
      if (pv[i]) begin
        pu[i*UOP_W +: UOP_W] = mem_u[idx[AW-1:0]];
        pb[i] = mem_b[idx[AW-1:0]];
      end
    end
  end

  assign nrp = (rp + LW'(LANES) >= len) ? '0 : rp + LW'(LANES);

  always_ff @(posedge clk) begin
    if (cap_store) begin
      mem_u[wp[AW-1:0]] <= cap_uop;
      mem_b[wp[AW-1:0]] <= cap_br;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= S_IDLE;
      wp         <= '0;
      len        <= '0;
      rp         <= '0;
      cnt_uops   <= '0;
      cnt_cycles <= '0;
    end else if (flush) begin
      mode <= S_IDLE;
      wp   <= '0;
      len  <= '0;
      rp   <= '0;
    end else if (start) begin
      mode       <= S_CAPT;
      wp         <= '0;
      len        <= '0;
      rp         <= '0;
      cnt_uops   <= '0;
      cnt_cycles <= '0;
    end else begin
      case (mode)
        S_CAPT: begin
          if (cap_over) begin
            mode <= S_IDLE;
            wp   <= '0;
          end else if (cap_fire) begin
            wp <= wp + 1'b1;
            if (cap_br) begin
              len  <= wp + 1'b1;
              rp   <= '0;
              mode <= S_PLAY;
            end
          end
        end
        S_PLAY: begin
          if (adv) begin
            rp         <= nrp;
            cnt_uops   <= cnt_uops + CNT_W'($countones(pv));
            cnt_cycles <= cnt_cycles + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign out_valid = playing ? pv : dec_valid;
  assign out_uop   = playing ? pu : dec_uop;
  assign out_br    = playing ? pb : dec_br;
endmodule

// File: rtl/loop_replay_chk.sv
module loop_replay_chk #(
  parameter int UOP_W = 16,
  parameter int DEPTH = 28,
  parameter int CNT_W = 32,
  parameter int LW    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               flush,
  input logic               cap_valid,
  input logic               out_ready,
  input logic               playing,
  input logic               capturing,
  input logic [LW-1:0]      wp,
  input logic [3:0]         out_valid,
  input logic [4*UOP_W-1:0] out_uop,
  input logic [3:0]         out_br,
  input logic [CNT_W-1:0]   cnt_uops,
  input logic [CNT_W-1:0]   cnt_cycles
);
  assert_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    playing |-> (out_valid == 4'b0001 || out_valid == 4'b0011 ||
                 out_valid == 4'b0111 || out_valid == 4'b1111));

  assert_br_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    playing |-> ((out_br & ~out_valid) == 4'b0 && (out_br & (out_valid >> 1)) == 4'b0));

  assert_cycle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && out_ready && !flush && !start) |=> (cnt_cycles == $past(cnt_cycles) + CNT_W'(1)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && !out_ready && !flush && !start) |=>
      ($stable(out_valid) && $stable(out_uop) && $stable(out_br) && $stable(cnt_uops)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && cap_valid && wp == LW'(DEPTH) && !flush && !start) |=> (!playing && !capturing));

  assert_flush_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!playing && !capturing));
endmodule

bind loop_replay_buf loop_replay_chk #(.UOP_W(UOP_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .flush(flush), .cap_valid(cap_valid),
  .out_ready(out_ready), .playing(playing), .capturing(capturing), .wp(wp),
  .out_valid(out_valid), .out_uop(out_uop), .out_br(out_br),
  .cnt_uops(cnt_uops), .cnt_cycles(cnt_cycles));

// File: tb/sim_loop_replay_buf.sv
module sim_loop_replay_buf;
  localparam int W = 16;
  localparam int D = 28;
  localparam int CW = 32;

  logic clk = 0, rst_n = 0, start = 0, flush = 0, cap_valid = 0, cap_br = 0, out_ready = 0;
  logic [W-1:0]   cap_uop = '0;
  logic [3:0]     dec_valid = 4'b1010, dec_br = 4'b0100;
  logic [4*W-1:0] dec_uop = {16'h0DD3, 16'h0DD2, 16'h0DD1, 16'h0DD0};
  logic [3:0]     out_valid, out_br;
  logic [4*W-1:0] out_uop;
  logic [CW-1:0]  cnt_uops, cnt_cycles;

  loop_replay_buf #(.UOP_W(W), .DEPTH(D), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .flush(flush), .cap_valid(cap_valid),
    .cap_uop(cap_uop), .cap_br(cap_br), .dec_valid(dec_valid), .dec_uop(dec_uop),
    .dec_br(dec_br), .out_ready(out_ready), .out_valid(out_valid), .out_uop(out_uop),
    .out_br(out_br), .cnt_uops(cnt_uops), .cnt_cycles(cnt_cycles));

  always #10 clk = ~clk;

  typedef struct { logic [3:0] v; logic [3:0] b; logic [4*W-1:0] u; } grp_t;
  grp_t q[$];
  grp_t mg;
  int total = 0, fails = 0, cyc = 0, rc = 0;
  bit mon_on = 0;

  task automatic chk(bit ok, string tag, logic [79:0] act, logic [79:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pass(string tag);
    chk(out_valid == dec_valid && out_uop == dec_uop && out_br == dec_br, tag,
        {out_valid, out_br, out_uop}, {dec_valid, dec_br, dec_uop});
  endtask

  always @(negedge clk) begin
    if (mon_on && q.size() != 0) begin
      mg = q[0];
      chk(out_valid == mg.v && out_br == mg.b && out_uop == mg.u,
          out_ready ? "R2 R3 R4 R9 group" : "R6 hold",
          {out_valid, out_br, out_uop}, {mg.v, mg.b, mg.u});
      if (out_ready) void'(q.pop_front());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic capture(int L, int base, bit close);
    for (int i = 0; i < L; i++) begin
      cap_valid = 1; cap_uop = W'(base + i); cap_br = close && (i == L - 1);
      @(posedge clk); #1;
    end
    cap_valid = 0; cap_br = 0;
  endtask

  task automatic pulse_start();
    start = 1; @(posedge clk); #1; start = 0;
  endtask

  task automatic run_loop(int L, int K, int base);
    grp_t g;
    pulse_start();
    capture(L, base, 1);
    for (int k = 0; k < K; k++)
      for (int p = 0; p < L; p += 4) begin
        int n;
        n = (L - p < 4) ? L - p : 4;
        g.v = 4'((1 << n) - 1);
        g.b = (p + n == L) ? 4'(1 << (n - 1)) : 4'b0;
        g.u = '0;
        for (int i = 0; i < n; i++) g.u[i*W +: W] = W'(base + p + i);
        q.push_back(g);
      end
    mon_on = 1;
    do begin
      rc++;
      out_ready = (rc % 5) != 3;
      @(posedge clk); #1;
    end while (q.size() != 0);
    out_ready = 0; mon_on = 0;
    chk(cnt_cycles == CW'(K * ((L + 3) / 4)), "R5 cycles", 80'(cnt_cycles), 80'(K * ((L + 3) / 4)));
    chk(cnt_uops == CW'(K * L), "R5 uops", 80'(cnt_uops), 80'(K * L));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk_pass("R1 reset pass-through");
    chk(cnt_uops == 0 && cnt_cycles == 0, "R1 reset counters", 80'({cnt_uops, cnt_cycles}), 80'(0));

    run_loop(7, 4, 16'h0700);
    for (int L = 1; L <= D; L++) run_loop(L, 3, L * 64);

    // R7: one entry beyond capacity without a closing branch
    pulse_start();
    capture(3, 16'h0900, 0);
    chk_pass("R1 pass-through during capture");
    capture(D - 3, 16'h0903, 0);
    chk_pass("R7 at capacity still capturing");
    capture(1, 16'h0980, 0);
    chk_pass("R7 overflow pass-through");
    capture(2, 16'h0990, 1);
    chk_pass("R7 capture ignored after overflow");
    @(posedge clk); #1;
    chk_pass("R7 no replay after overflow");

    // R8: flush in mid-replay
    pulse_start();
    capture(6, 16'h0A00, 1);
    out_ready = 1;
    repeat (3) @(posedge clk);
    #1 out_ready = 1;
    chk(out_valid != dec_valid || out_uop != dec_uop, "R8 replaying before flush",
        {out_valid, out_br, out_uop}, 80'(0));
    flush = 1; @(posedge clk); #1; flush = 0;
    chk_pass("R8 pass-through after flush");
    capture(3, 16'h0B00, 1);
    @(posedge clk); #1;
    chk_pass("R8 capture ignored after flush");
    out_ready = 0;

    // R2: new start after flush captures again
    run_loop(5, 2, 16'h0C00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule